// File: doc/BRIEF.md
# Timeout Interrupt Status and Enable Registers

This block keeps the pending state and the enable for one interrupt source: a timeout raised when an asynchronous memory access waits too long for its ready signal. A one-cycle `timeoutPulse` from the access engine records the event. The `irqOut` line goes to the interrupt controller. Software reaches the state through four word-wide registers on a plain address, write-enable, write-data and read-data port. Reads are combinational from `regAddr`.

Only bit 0 of each register carries meaning. Writes act only when bit 0 of the write data is 1, so writing 0 never changes anything. The register map is:

| Address | Role |
|---|---|
| 0 | raw pending flag |
| 1 | gated pending flag |
| 2 | enable-set |
| 3 | enable-clear |

A write of 1 to either pending register clears both pending flags. The enable bit can only be changed through the set and clear registers, and both of them read back the current enable value.

Top module: `tmo_irq_regs`

## Requirements
- R1: After reset, all four registers read 0, the enable is off and `irqOut` is 0.
- R2: A `timeoutPulse` sets the raw flag (address 0, bit 0) whether or not the enable is on.
- R3: A `timeoutPulse` sets the gated flag (address 1, bit 0) only while the enable is 1, and `irqOut` always equals the gated flag.
- R4: Writing a word with bit 0 = 1 to address 0 clears both the raw and the gated flags on the next clock edge.
- R5: Writing a word with bit 0 = 1 to address 1 clears both the raw and the gated flags on the next clock edge.
- R6: A write whose bit 0 is 0 changes no state, whatever its other bits and whichever register it targets.
- R7: Writing bit 0 = 1 to address 2 turns the enable on, after which addresses 2 and 3 both read 1.
- R8: Writing bit 0 = 1 to address 3 turns the enable off, after which addresses 2 and 3 both read 0.
- R9: When a `timeoutPulse` arrives in the same cycle as a clearing write, the flags end up set.
- R10: Bits above bit 0 of every register always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register address for reads and writes |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | DATA_W | Write data; only bit 0 is used |
| regRdData | output | DATA_W | Read data for `regAddr`; bit 0 only |
| timeoutPulse | input | 1 | One-cycle access timeout event |
| irqOut | output | 1 | Interrupt request, equal to the gated flag |

## Verification
The bench raises a timeout while the enable is off. A design that gates the raw flag would leave address 0 at 0, and a design that sets the gated flag anyway would raise `irqOut`. Each pending register is cleared on its own, and both flags are checked after each clear, so a design that clears only its own view leaves a stale bit behind. Writes with bit 0 = 0 and all other bits set go to every register, which catches decoders that test the whole word. A timeout coincides with a clear, which catches a design where the clear wins. Every read compares the full word, so stray upper bits show up.

// File: rtl/tmo_irq_pkg.sv
package tmo_irq_pkg;
  typedef enum logic [1:0] {
    SEL_RAW    = 2'd0,
    SEL_MASKED = 2'd1,
    SEL_ENSET  = 2'd2,
    SEL_ENCLR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic clrStatus;
    logic setEnable;
    logic clrEnable;
  } ctlStrobe_t;
endpackage

// File: rtl/tmo_irq_ctrl.sv
module tmo_irq_ctrl
  import tmo_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output ctlStrobe_t        strobe,
  output regSel_e           rdSel,
  output logic              rdHit
);
  localparam int SEL_W = 2;

  logic inRange;
  logic wrOne;

  generate
    if (ADDR_W > SEL_W) begin : g_wideAddr
      assign inRange = (regAddr[ADDR_W-1:SEL_W] == '0);
    end else begin : g_narrowAddr
      assign inRange = 1'b1;
    end
  endgenerate

  assign rdSel = regSel_e'(regAddr[SEL_W-1:0]);
  assign rdHit = inRange;
  assign wrOne = regWrEn && inRange && regWrData[0];

  always_comb begin
    strobe = '0;
    if (wrOne) begin
      unique case (rdSel)
        SEL_RAW, SEL_MASKED: strobe.clrStatus = 1'b1;
        SEL_ENSET:           strobe.setEnable = 1'b1;
        SEL_ENCLR:           strobe.clrEnable = 1'b1;
      endcase
    end
  end

  // R6: at most one action per write; a zero in bit 0 yields no action
  p_one_action_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrStatus, strobe.setEnable, strobe.clrEnable}));
  p_zero_write_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrData[0]) |-> (strobe == '0));
endmodule

// File: rtl/tmo_irq_dpath.sv
module tmo_irq_dpath
  import tmo_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  regSel_e           rdSel,
  input  logic              rdHit,
  input  logic              timeoutPulse,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic rawQ;
  logic maskedQ;
  logic enQ;
  logic rdBit;

  // hardware set takes priority over a software clear (R9)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ    <= 1'b0;
      maskedQ <= 1'b0;
      enQ     <= 1'b0;
    end else begin
      if (timeoutPulse)         rawQ <= 1'b1;
      else if (strobe.clrStatus) rawQ <= 1'b0;

      if (timeoutPulse && enQ)  maskedQ <= 1'b1;
      else if (strobe.clrStatus) maskedQ <= 1'b0;

      if (strobe.setEnable)      enQ <= 1'b1;
      else if (strobe.clrEnable) enQ <= 1'b0;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_RAW:    rdBit = rawQ;
      SEL_MASKED: rdBit = maskedQ;
      SEL_ENSET:  rdBit = enQ;
      SEL_ENCLR:  rdBit = enQ;
    endcase
    if (!rdHit) rdBit = 1'b0;
  end

  assign regRdData = {{(DATA_W-1){1'b0}}, rdBit};
  assign irqOut    = maskedQ;

  p_raw_on_event_r2: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> rawQ);
  p_masked_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutPulse && enQ) |=> maskedQ);
  p_no_masked_when_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && !maskedQ) |=> !maskedQ);
  p_masked_needs_raw_r3: assert property (@(posedge clk) disable iff (!rstN)
    maskedQ |-> rawQ);
  p_clear_both_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrStatus && !timeoutPulse) |=> (!rawQ && !maskedQ));
  p_enable_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setEnable |=> enQ);
  p_enable_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEnable |=> !enQ);
endmodule

// File: rtl/tmo_irq_regs.sv
module tmo_irq_regs
  import tmo_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              timeoutPulse,
  output logic              irqOut
);
  ctlStrobe_t strobe;
  regSel_e    rdSel;
  logic       rdHit;

  tmo_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .strobe(strobe), .rdSel(rdSel), .rdHit(rdHit)
  );

  tmo_irq_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .rdHit(rdHit),
    .timeoutPulse(timeoutPulse), .regRdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/tmo_irq_regs_bench.sv
module tmo_irq_regs_bench;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  typedef struct {
    int                addr;
    logic [DATA_W-1:0] expData;
    logic              expIrq;
    string             tag;
  } expItem_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic              timeoutPulse = 1'b0;
  logic              irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  expItem_t expQ[$];

  // model state derived from the requirements
  bit rawM = 0, mskM = 0, enM = 0;

  always #5 clk = ~clk;

  tmo_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tmo_irq_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .timeoutPulse(timeoutPulse), .irqOut(irqOut)
  );

  // monitor: compare against the oldest expected item
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (regRdData !== it.expData || irqOut !== it.expIrq) begin
        errors++;
        $display("FAIL %s: addr %0d data %h exp %h irq %b exp %b",
                 it.tag, it.addr, regRdData, it.expData, irqOut, it.expIrq);
      end
    end
  end

  function automatic logic modelBit(int a);
    case (a)
      0: return rawM;
      1: return mskM;
      default: return enM;
    endcase
  endfunction

  task automatic readChk(int a, string tag);
    expItem_t it;
    @(posedge clk); #1;
    regAddr = a[ADDR_W-1:0];
    it.addr = a;
    it.expData = {{(DATA_W-1){1'b0}}, modelBit(a)};
    it.expIrq = mskM;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic readAll(string tag);
    for (int a = 0; a < 4; a++) readChk(a, tag);
  endtask

  // one bus write, optionally with a coincident timeout event
  task automatic busWr(int a, logic [DATA_W-1:0] d, bit withEvt);
    @(posedge clk); #1;
    regAddr = a[ADDR_W-1:0];
    regWrData = d;
    regWrEn = 1'b1;
    timeoutPulse = withEvt;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    timeoutPulse = 1'b0;
    regWrData = '0;
    if (d[0]) begin
      if (a <= 1) begin rawM = 0; mskM = 0; end
      if (a == 2) enM = 1;
      if (a == 3) enM = 0;
    end
    if (withEvt) begin
      rawM = 1;
      if (enM || (a == 2 && d[0] && 1'b0)) mskM = 1;
    end
  endtask

  task automatic pulseEvt();
    @(posedge clk); #1;
    timeoutPulse = 1'b1;
    @(posedge clk); #1;
    timeoutPulse = 1'b0;
    rawM = 1;
    if (enM) mskM = 1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    readAll("R1 reset state, R10 upper bits");

    pulseEvt();
    readAll("R2 raw set with enable off, R3 gated stays 0");

    busWr(0, 32'hFFFF_FFFE, 0);
    busWr(1, 32'hFFFF_FFFE, 0);
    busWr(2, 32'hFFFF_FFFE, 0);
    readAll("R6 zero bit0 writes ignored");

    busWr(0, 32'h1, 0);
    readAll("R4 raw clear");

    busWr(2, 32'h1, 0);
    readAll("R7 enable set reads on both");
    busWr(3, 32'hFFFF_FFFE, 0);
    readAll("R6 zero write to enable-clear ignored");

    pulseEvt();
    readAll("R3 gated set with enable on");

    busWr(1, 32'h1, 0);
    readAll("R5 masked clear clears both");

    pulseEvt();
    busWr(0, 32'hFFFF_FFFF, 0);
    readAll("R4 raw clear clears gated too");

    busWr(1, 32'h1, 1);
    readAll("R9 event beats clear");

    busWr(3, 32'h1, 0);
    busWr(0, 32'h1, 0);
    readAll("R8 enable cleared");

    pulseEvt();
    readAll("R3 gated blocked after disable");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule